// File: doc/BRIEF.md
# Fixed-Length Command Frame Assembler

This block sits between a host link that delivers a stream of 32-bit words and a command executor. It groups the incoming words into frames of exactly nine words. Positions are counted from zero: position 0 is the opcode, positions 1 to 7 are arguments, and position 8 is a closing marker. An instruction that needs fewer arguments fills the unused argument slots with the padding word 0x8000_8000. The assembler passes that word through like any other value.

When the closing word equals the marker parameter, the opcode and the seven arguments appear together on a parallel output with `out_valid` raised. The frame stays there unchanged until the executor takes it with `out_ready`. While a finished frame is waiting, the input side is stalled, so the block buffers one frame at most. If the closing word differs from the marker, the whole frame is thrown away. The block then raises a one-cycle error pulse and the next accepted word is taken as a new opcode. A synchronous reset discards any partly collected frame.

Top module: `cmd_frame_asm`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `out_valid` and `frm_err` are low and `in_ready` is high.
- R2: In a delivered frame, `out_opcode` is the word accepted at position 0. Argument k (k = 1..7) is the word accepted at position k and appears on `out_args[(k-1)*32 +: 32]`.
- R3: When the word accepted at position 8 equals `END_MARK`, `out_valid` is high in the cycle after that acceptance, and `frm_err` stays low.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_opcode` and `out_args` keep their values into the next cycle.
- R5: `in_ready` is low whenever `out_valid` is high. Input words offered during that time are not taken.
- R6: When the word accepted at position 8 differs from `END_MARK` in any bit, no frame is delivered. `frm_err` is high for exactly the one cycle after that acceptance, and the next accepted word is position 0 of a new frame.
- R7: The padding word 0x8000_8000 in an argument slot is delivered unchanged in that slot.
- R8: Cycles with `in_valid` low between words do not change the position count.
- R9: A synchronous reset in the middle of a frame discards the words collected so far. The next accepted word is position 0.
- R10: If `out_ready` is already high, `out_valid` is high for exactly one cycle per frame and `in_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Assembled frame is on the output |
| out_ready | input | 1 | Executor takes the frame |
| out_opcode | output | 32 | Word at position 0 |
| out_args | output | 224 | Words at positions 1..7, argument 1 in the low bits |
| frm_err | output | 1 | One-cycle pulse when a frame's closing word does not match the marker |

## Verification
The marker check is swept over a single-bit corruption in each of the 32 bit positions. This shows that every bit of the closing word is compared, and that the frame after each rejected one lines up at position 0 again. Good frames are sent with idle gaps of 0 to 3 cycles between words and with padding in a varying number of trailing argument slots. This separates a correct position count from one that advances on idle cycles, and it shows whether each word lands in its own slot. A series of frames is sent while the executor stalls each delivery for a different number of cycles, and one corrupted frame is placed in the middle of the series. This tests output holding, input stalling and error recovery while the two sides interact. A reset in the middle of a frame and a zero-wait executor cover the remaining orderings.

// File: rtl/cmd_frm_pkg.sv
package cmd_frm_pkg;
    localparam int unsigned DEF_WORD_W    = 32;
    localparam int unsigned DEF_FRAME_LEN = 9;
    localparam logic [31:0] DEF_END_MARK  = 32'hE0F0_5A09;

    typedef enum logic {
        OS_COLLECT = 1'b0,
        OS_PENDING = 1'b1
    } out_state_e;
endpackage

// File: rtl/cmd_frm_ctr.sv
module cmd_frm_ctr #(
    parameter int unsigned FRAME_LEN = 9,
    localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.idx == LAST_IDX) st_d.idx = '0;
            else                      st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx     = st_q.idx;
    assign at_last = (st_q.idx == LAST_IDX);
endmodule

// File: rtl/cmd_frm_store.sv
module cmd_frm_store #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [SLOTS*WORD_W-1:0] slots
);
    typedef struct packed {
        logic [SLOTS-1:0][WORD_W-1:0] word;
    } store_t;

    store_t st_d, st_q;
    logic [SLOTS-1:0] hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign hit[s] = wr_en && (wr_idx == IDX_W'(s));
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < SLOTS; s++) begin
            if (hit[s]) st_d.word[s] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slots = st_q.word;
endmodule

// File: rtl/cmd_frm_out.sv
module cmd_frm_out
    import cmd_frm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mark_seen,
    input  logic mark_ok,
    input  logic take,
    output logic pending,
    output logic err
);
    typedef struct packed {
        out_state_e state;
        logic       err;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (st_q.state)
            OS_COLLECT: begin
                if (mark_seen) begin
                    if (mark_ok) st_d.state = OS_PENDING;
                    else         st_d.err   = 1'b1;
                end
            end
            OS_PENDING: begin
                if (take) st_d.state = OS_COLLECT;
            end
            default: st_d.state = OS_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{state: OS_COLLECT, err: 1'b0};
        else     st_q <= st_d;
    end

    assign pending = (st_q.state == OS_PENDING);
    assign err     = st_q.err;
endmodule

// File: rtl/cmd_frame_asm.sv
module cmd_frame_asm
    import cmd_frm_pkg::*;
#(
    parameter int unsigned     WORD_W    = DEF_WORD_W,
    parameter int unsigned     FRAME_LEN = DEF_FRAME_LEN,
    parameter logic [WORD_W-1:0] END_MARK = WORD_W'(DEF_END_MARK),
    localparam int unsigned    SLOTS     = FRAME_LEN - 1,
    localparam int unsigned    ARGS      = FRAME_LEN - 2,
    localparam int unsigned    IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WORD_W-1:0]      in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [WORD_W-1:0]      out_opcode,
    output logic [ARGS*WORD_W-1:0] out_args,
    output logic                   frm_err
);
    logic                    accept;
    logic                    at_last;
    logic [IDX_W-1:0]        word_idx;
    logic [SLOTS*WORD_W-1:0] slot_bus;
    logic                    pending;

    assign in_ready = !pending;
    assign accept   = in_valid && in_ready;

    cmd_frm_ctr #(
        .FRAME_LEN(FRAME_LEN)
    ) ctr_i (
        .clk    (clk),
        .rst    (rst),
        .adv    (accept),
        .idx    (word_idx),
        .at_last(at_last)
    );

    cmd_frm_store #(
        .WORD_W(WORD_W),
        .SLOTS (SLOTS),
        .IDX_W (IDX_W)
    ) store_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept && !at_last),
        .wr_idx (word_idx),
        .wr_data(in_data),
        .slots  (slot_bus)
    );

    cmd_frm_out out_i (
        .clk      (clk),
        .rst      (rst),
        .mark_seen(accept && at_last),
        .mark_ok  (in_data == END_MARK),
        .take     (out_ready),
        .pending  (pending),
        .err      (frm_err)
    );

    assign out_valid  = pending;
    assign out_opcode = slot_bus[WORD_W-1:0];
    assign out_args   = slot_bus[SLOTS*WORD_W-1:WORD_W];
endmodule

// File: rtl/cmd_frame_asm_chk.sv
module cmd_frame_asm_chk #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned FRAME_LEN = 9,
    parameter int unsigned IDX_W     = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_ready,
    input logic                            out_valid,
    input logic                            out_ready,
    input logic [WORD_W-1:0]               out_opcode,
    input logic [(FRAME_LEN-2)*WORD_W-1:0] out_args,
    input logic                            frm_err,
    input logic [IDX_W-1:0]                word_idx
);
    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !frm_err && in_ready && word_idx == '0));

    a_r4_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    a_r4_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_opcode) && $stable(out_args)));

    a_r5_stall_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
        frm_err |=> !frm_err);

    a_r6_err_resync: assert property (@(posedge clk) disable iff (rst)
        frm_err |-> (word_idx == '0 && !out_valid));

    a_r3_clean_delivery: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !frm_err);

    a_r8_idx_bound: assert property (@(posedge clk) disable iff (rst)
        word_idx < IDX_W'(FRAME_LEN));
endmodule

bind cmd_frame_asm cmd_frame_asm_chk #(
    .WORD_W   (WORD_W),
    .FRAME_LEN(FRAME_LEN),
    .IDX_W    (IDX_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_opcode(out_opcode),
    .out_args  (out_args),
    .frm_err   (frm_err),
    .word_idx  (word_idx)
);

// File: tb/cmd_frame_asm_tb_top.sv
module cmd_frame_asm_tb_top;
    localparam logic [31:0] MARK = 32'hE0F0_5A09;
    localparam logic [31:0] PAD  = 32'h8000_8000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_opcode;
    logic [223:0] out_args;
    logic         frm_err;

    int n_chk  = 0;
    int n_fail = 0;
    int n_err  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmd_frame_asm #(.END_MARK(MARK)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_opcode(out_opcode),
        .out_args  (out_args),
        .frm_err   (frm_err)
    );

    always @(negedge clk) if (!rst && frm_err) n_err++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wv(input int f, input int j);
        if (j >= 2 && j > (f % 7) + 1) return PAD;
        return {16'(f) ^ 16'hA5C3, 8'(j), 8'(f * 7 + j)};
    endfunction

    task automatic push(input logic [31:0] w, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input int f, input logic [31:0] mk, input int gap);
        for (int j = 0; j < 8; j++) push(wv(f, j), gap);
        push(mk, gap);
    endtask

    task automatic check_frame(input int f, input string req);
        chk(out_opcode == wv(f, 0), {req, " R2 opcode"}, out_opcode, wv(f, 0));
        for (int k = 1; k < 8; k++) begin
            chk(out_args[(k-1)*32 +: 32] == wv(f, k),
                (wv(f, k) == PAD) ? {req, " R7 pad slot"} : {req, " R2 arg"},
                out_args[(k-1)*32 +: 32], wv(f, k));
        end
    endtask

    task automatic take_frame();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid && !frm_err && in_ready, "R1 reset outputs",
            {29'd0, out_valid, frm_err, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !frm_err && in_ready, "R1 after release",
            {29'd0, out_valid, frm_err, in_ready}, 32'd1);

        // R3 R8 good frames with idle gaps 0..3, held for a few cycles (R4 R5)
        for (int g = 0; g < 4; g++) begin
            send_frame(g, MARK, g);
            @(negedge clk);
            chk(out_valid && !frm_err, "R3 valid after marker",
                {30'd0, out_valid, frm_err}, 32'd2);
            check_frame(g, "R8 gap frame");
            for (int h = 0; h < 3; h++) begin
                in_valid = 1'b1;
                in_data  = 32'hDEAD_0000 + h;
                @(negedge clk);
                chk(out_valid && !in_ready && out_opcode == wv(g, 0),
                    "R4 R5 held and stalled", out_opcode, wv(g, 0));
            end
            in_valid = 1'b0;
            take_frame();
            chk(!out_valid && in_ready, "R4 released by ready",
                {30'd0, out_valid, in_ready}, 32'd1);
        end

        // R6 sweep over single-bit marker corruptions
        for (int b = 0; b < 32; b++) begin
            send_frame(40 + b, MARK ^ (32'd1 << b), 0);
            @(negedge clk);
            chk(frm_err && !out_valid, "R6 bad marker flagged",
                {30'd0, frm_err, out_valid}, 32'd2);
            @(negedge clk);
            chk(!frm_err, "R6 error lasts one cycle", {31'd0, frm_err}, 32'd0);
        end
        send_frame(80, MARK, 0);
        @(negedge clk);
        chk(out_valid, "R6 resync after bad frames", {31'd0, out_valid}, 32'd1);
        check_frame(80, "R6 resync");
        take_frame();

        // R9 reset in the middle of a frame
        for (int j = 0; j < 4; j++) push(32'h1111_0000 + j, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send_frame(90, MARK, 0);
        @(negedge clk);
        chk(out_valid && !frm_err, "R9 clean frame after reset",
            {30'd0, out_valid, frm_err}, 32'd2);
        check_frame(90, "R9");
        take_frame();

        // R10 executor always ready
        out_ready = 1'b1;
        send_frame(95, MARK, 1);
        @(negedge clk);
        chk(out_valid, "R10 strobe high", {31'd0, out_valid}, 32'd1);
        check_frame(95, "R10");
        @(negedge clk);
        chk(!out_valid && in_ready, "R10 strobe one cycle",
            {30'd0, out_valid, in_ready}, 32'd1);
        out_ready = 1'b0;

        // R4 R5 R6 back-pressure across several frames with one bad frame
        e0 = n_err;
        fork
            begin
                for (int f = 100; f < 106; f++)
                    send_frame(f, (f == 102) ? (MARK ^ 32'h0100_0000) : MARK, f % 2);
            end
            begin
                for (int f = 100; f < 106; f++) begin
                    if (f != 102) begin
                        @(negedge clk);
                        while (!out_valid) @(negedge clk);
                        for (int h = 0; h < (f % 4) + 1; h++) begin
                            @(negedge clk);
                            chk(out_valid && !in_ready, "R5 stall under back-pressure",
                                {30'd0, out_valid, in_ready}, 32'd2);
                        end
                        check_frame(f, "R4 back-pressure");
                        out_ready = 1'b1;
                        @(negedge clk);
                        out_ready = 1'b0;
                    end
                end
            end
        join
        repeat (2) @(negedge clk);
        chk(n_err - e0 == 1, "R6 one error in series", 32'(n_err - e0), 32'd1);
        chk(!out_valid, "R6 bad frame not delivered", {31'd0, out_valid}, 32'd0);

        finish_run();
    end
endmodule